// File: doc/BRIEF.md
# Reloadable Down-Counter Compare Timer

This block is a 32-bit periodic timer. A small word-addressed register bus reaches five registers: control, status, load value, compare value and a read-only view of the live count. One of three free-running tick-enable inputs is chosen as the time base and divided by a 12-bit prescaler. Each divided tick moves a down-counter by one. When the counter reaches zero it either reloads from the load register or wraps to all-ones, whichever mode is chosen.

When a counter step lands on the compare value, a sticky status flag is set. A level interrupt follows the flag, gated by an interrupt-enable bit and the run bit. Software can force the count at once through the load register, and can make the rising edge of the run bit restart the count. A self-clearing soft reset returns most state to defaults but keeps the run and power-mode bits.

Top module: `reload_cmp_timer`

## Requirements
- R1: After hardware reset, control, status and compare read 0, load and count read 0xFFFFFFFF, and `irq` is low.
- R2: The registers sit at word addresses 0 (control), 1 (status, flag in bit 0), 2 (load), 3 (compare) and 4 (count). Any other address reads 0. Writes to the count address are ignored. Control stores bits [25:0] of a write, and bits [31:26] read as 0. The control layout is: run bit 0, restart-on-run bit 1, interrupt enable bit 2, reload mode bit 3, prescaler [15:4], soft reset bit 16, force-load bit 17, stored-only power bits [21:18], source [23:22], stored-only bits [25:24].
- R3: Source 00 freezes the counter. Sources 01, 10 and 11 take `tick_periph`, `tick_fast` and `tick_slow`. Ticks on inputs that are not selected do nothing.
- R4: With prescaler value d and the selected tick always high, the counter moves by one every d+1 cycles. The first step lands d+1 cycles after the edge that sets the run bit.
- R5: A step from 0 loads the load register when reload mode is set, and all-ones when it is clear.
- R6: A control write that takes the run bit from 0 to 1 with restart-on-run set loads the counter: the load register in reload mode, all-ones otherwise. Without restart-on-run the count is kept. The count holds while the run bit is 0.
- R7: A load write while force-load is set puts the written value into the counter on the same edge, and this wins over a step on that edge. Without force-load, a load write leaves the count alone.
- R8: A step that lands on the compare value sets the status flag. Writing 1 to status bit 0 clears it, and writing 0 has no effect. If a set and a clear fall on the same edge, the set wins.
- R9: `irq` is high exactly when the flag, the interrupt enable bit and the run bit are all set.
- R10: A control write with the soft-reset bit shows that bit for one cycle. On the next edge control keeps only bits 0, 1 and [21:18]; load and count become 0xFFFFFFFF; status and compare become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_periph | input | 1 | Tick enable, source 01 |
| tick_fast | input | 1 | Tick enable, source 10 |
| tick_slow | input | 1 | Tick enable, source 11 |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level compare interrupt |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a compare hit and a write-1 clear of the status flag. The bench forces a known count, starts the timer with prescaler 0, and counts edges so that the clear write lands on the exact edge where the count reaches the compare value. It then expects the flag to read 1. The second pair is a forced load and a prescaler step: a force-load write is issued while the counter steps every cycle, and the count must read back the written value rather than that value minus one.

// File: rtl/rct_pkg.sv
package rct_pkg;
  localparam int DIV_W  = 12;
  localparam int CTL_W  = 26;

  localparam int B_RUN     = 0;
  localparam int B_RESTART = 1;
  localparam int B_IRQEN   = 2;
  localparam int B_RELOAD  = 3;
  localparam int B_DIV     = 4;
  localparam int B_SRST    = 16;
  localparam int B_FORCE   = 17;
  localparam int B_PWR0    = 18;
  localparam int B_PWR3    = 21;
  localparam int B_SRC     = 22;

  localparam logic [CTL_W-1:0] KEEP_MASK =
    CTL_W'((1 << B_RUN) | (1 << B_RESTART) | (15 << B_PWR0));

  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_PERIPH = 2'd1,
    SRC_FAST   = 2'd2,
    SRC_SLOW   = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    A_CTL  = 3'd0,
    A_STAT = 3'd1,
    A_LOAD = 3'd2,
    A_CMP  = 3'd3,
    A_CNT  = 3'd4
  } addr_e;
endpackage

// File: rtl/rct_prescaler.sv
module rct_prescaler
  import rct_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [1:0]    src_i,
  input  logic          tick_periph_i,
  input  logic          tick_fast_i,
  input  logic          tick_slow_i,
  input  logic [DW-1:0] div_i,
  output logic          step_o
);
  function automatic logic pick_tick(input logic [1:0] src, input logic p,
                                     input logic f, input logic s);
    case (src_e'(src))
      SRC_PERIPH: return p;
      SRC_FAST:   return f;
      SRC_SLOW:   return s;
      default:    return 1'b0;
    endcase
  endfunction

  logic [DW-1:0] div_cnt;
  logic          tick_sel;
  logic          at_top;

  assign tick_sel = pick_tick(src_i, tick_periph_i, tick_fast_i, tick_slow_i);
  assign at_top   = (div_cnt >= div_i);
  assign step_o   = en_i & tick_sel & at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_cnt <= '0;
    else if (!en_i)    div_cnt <= '0;
    else if (tick_sel) div_cnt <= at_top ? '0 : div_cnt + 1'b1;
  end

  // R3
  src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == 2'd0) |-> !step_o);

  // R4
  step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && div_i != '0) |=> (!step_o || div_i == '0));
endmodule

// File: rtl/rct_counter.sv
module rct_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              srst_i,
  input  logic              force_i,
  input  logic [DATA_W-1:0] force_val_i,
  input  logic              restart_i,
  input  logic              restart_reload_i,
  input  logic              reload_i,
  input  logic [DATA_W-1:0] load_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              adv_o,
  output logic [DATA_W-1:0] adv_val_o
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  function automatic logic [DATA_W-1:0] wrap_value(input logic reload,
                                                   input logic [DATA_W-1:0] load);
    return reload ? load : ALL_ONES;
  endfunction

  function automatic logic [DATA_W-1:0] next_down(input logic [DATA_W-1:0] cur,
                                                  input logic reload,
                                                  input logic [DATA_W-1:0] load);
    return (cur == '0) ? wrap_value(reload, load) : cur - 1'b1;
  endfunction

  logic [DATA_W-1:0] cnt_q;

  assign adv_o     = step_i & ~srst_i & ~force_i & ~restart_i;
  assign adv_val_o = next_down(cnt_q, reload_i, load_i);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= ALL_ONES;
    else if (srst_i)    cnt_q <= ALL_ONES;
    else if (force_i)   cnt_q <= force_val_i;
    else if (restart_i) cnt_q <= wrap_value(restart_reload_i, load_i);
    else if (adv_o)     cnt_q <= adv_val_o;
  end

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !srst_i && !force_i && !restart_i) |=> $stable(cnt_q));

  // R5
  wrap_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_o && !reload_i && cnt_q == '0) |=> (cnt_q == ALL_ONES));

  // R5
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_o && reload_i && cnt_q == '0) |=> (cnt_q == $past(load_i)));

  // R7
  force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_i && !srst_i) |=> (cnt_q == $past(force_val_i)));

  // R10
  srst_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (cnt_q == ALL_ONES));
endmodule

// File: rtl/rct_flag.sv
module rct_flag #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_i,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] adv_val_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic              clr_i,
  output logic              flag_o
);
  logic flag_q;
  logic hit;

  assign hit    = adv_i && (adv_val_i == cmp_i);
  assign flag_o = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (srst_i) flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  // R8
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !srst_i) |=> flag_q);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit && !srst_i) |=> !flag_q);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i && !srst_i) |=> flag_q);
endmodule

// File: rtl/reload_cmp_timer.sv
module reload_cmp_timer
  import rct_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_periph,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] cmp_q;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] adv_val;
  logic              adv;
  logic              step;
  logic              flag;

  logic wr_ctl, wr_stat, wr_load, wr_cmp;
  logic srst, restart, force_ld, clr, run_en;

  assign wr_ctl  = bus_wr && (bus_addr == ADDR_W'(A_CTL));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT));
  assign wr_load = bus_wr && (bus_addr == ADDR_W'(A_LOAD));
  assign wr_cmp  = bus_wr && (bus_addr == ADDR_W'(A_CMP));

  assign srst     = ctl_q[B_SRST];
  assign restart  = wr_ctl && !srst && bus_wdata[B_RUN] && !ctl_q[B_RUN]
                    && bus_wdata[B_RESTART];
  assign force_ld = wr_load && ctl_q[B_FORCE] && !srst;
  assign clr      = wr_stat && bus_wdata[0];
  assign run_en   = ctl_q[B_RUN] && !srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (srst)   ctl_q <= ctl_q & KEEP_MASK;
    else if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= ALL_ONES;
    else if (srst)    load_q <= ALL_ONES;
    else if (wr_load) load_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (srst)   cmp_q <= '0;
    else if (wr_cmp) cmp_q <= bus_wdata;
  end

  rct_prescaler #(.DW(DIV_W)) u_presc (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (run_en),
    .src_i         (ctl_q[B_SRC +: 2]),
    .tick_periph_i (tick_periph),
    .tick_fast_i   (tick_fast),
    .tick_slow_i   (tick_slow),
    .div_i         (ctl_q[B_DIV +: DIV_W]),
    .step_o        (step)
  );

  rct_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk              (clk),
    .rst_n            (rst_n),
    .step_i           (step),
    .srst_i           (srst),
    .force_i          (force_ld),
    .force_val_i      (bus_wdata),
    .restart_i        (restart),
    .restart_reload_i (bus_wdata[B_RELOAD]),
    .reload_i         (ctl_q[B_RELOAD]),
    .load_i           (load_q),
    .cnt_o            (cnt),
    .adv_o            (adv),
    .adv_val_o        (adv_val)
  );

  rct_flag #(.DATA_W(DATA_W)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst_i    (srst),
    .adv_i     (adv),
    .adv_val_i (adv_val),
    .cmp_i     (cmp_q),
    .clr_i     (clr),
    .flag_o    (flag)
  );

  assign irq = flag && ctl_q[B_IRQEN] && ctl_q[B_RUN];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CTL):  bus_rdata = DATA_W'(ctl_q);
      ADDR_W'(A_STAT): bus_rdata = DATA_W'(flag);
      ADDR_W'(A_LOAD): bus_rdata = load_q;
      ADDR_W'(A_CMP):  bus_rdata = cmp_q;
      ADDR_W'(A_CNT):  bus_rdata = cnt;
      default:         bus_rdata = '0;
    endcase
  end

  // R10
  srst_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (load_q == ALL_ONES && cmp_q == '0 && !ctl_q[B_SRST] && !flag));

  // R2
  ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !srst) |=> (ctl_q == $past(bus_wdata[CTL_W-1:0])));
endmodule

// File: tb/reload_cmp_timer_bench.sv
module reload_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_periph = 1'b0, tick_fast = 1'b0, tick_slow = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  localparam logic [31:0] ONES    = 32'hFFFF_FFFF;
  localparam logic [31:0] K_RUN   = 32'h1;
  localparam logic [31:0] K_RST   = 32'h2;
  localparam logic [31:0] K_IEN   = 32'h4;
  localparam logic [31:0] K_RLD   = 32'h8;
  localparam logic [31:0] K_SRST  = 32'h1_0000;
  localparam logic [31:0] K_FORCE = 32'h2_0000;

  always #10 clk = ~clk;

  reload_cmp_timer u_reload_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick_periph(tick_periph), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [31:0] src_bits(input int s);
    return 32'(s) << 22;
  endfunction

  function automatic logic [31:0] div_bits(input int d);
    return 32'(d) << 4;
  endfunction

  function automatic logic [31:0] exp_count(input logic [31:0] start, input int d,
                                            input int k);
    return start - 32'(k / (d + 1));
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ticks(input logic p, input logic f, input logic s);
    tick_periph = p; tick_fast = f; tick_slow = s;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset values
    rd(3'd0, v); chk("R1", "ctl", v, 32'd0);
    rd(3'd1, v); chk("R1", "status", v, 32'd0);
    rd(3'd2, v); chk("R1", "load", v, ONES);
    rd(3'd3, v); chk("R1", "cmp", v, 32'd0);
    rd(3'd4, v); chk("R1", "count", v, ONES);
    chk("R1", "irq", 32'(irq), 32'd0);

    // R2 upper control bits dropped
    wr(3'd0, 32'hFFFE_FFFF);
    rd(3'd0, v); chk("R2", "ctl mask", v, 32'h03FE_FFFF);
    wr(3'd0, 32'd0);

    // R4 R6 random prescaler and restart runs
    for (int it = 0; it < 10; it++) begin
      int s, d, k;
      logic [31:0] ld;
      s  = 1 + int'($urandom_range(2, 0));
      d  = int'($urandom_range(7, 0));
      k  = 3 + int'($urandom_range(77, 0));
      ld = 32'(200 + $urandom_range(1000, 0));
      wr(3'd0, 32'd0);
      wr(3'd2, ld);
      set_ticks(s == 1, s == 2, s == 3);
      wr(3'd0, K_RUN | K_RST | K_RLD | src_bits(s) | div_bits(d));
      idle(k);
      rd(3'd4, v); chk("R4", "prescaled count", v, exp_count(ld, d, k));
    end
    wr(3'd0, 32'd0);

    // R3 source off freezes, unselected ticks ignored
    set_ticks(1, 1, 1);
    wr(3'd0, K_FORCE);
    wr(3'd2, 32'd100);
    rd(3'd4, v); chk("R7", "forced while stopped", v, 32'd100);
    wr(3'd0, K_RUN | K_FORCE);
    idle(10);
    rd(3'd4, v); chk("R3", "source off", v, 32'd100);
    set_ticks(0, 1, 1);
    wr(3'd0, K_RUN | src_bits(1));
    idle(10);
    rd(3'd4, v); chk("R3", "unselected ticks", v, 32'd100);
    set_ticks(1, 1, 1);
    idle(5);
    rd(3'd4, v); chk("R3", "selected tick", v, 32'd95);

    // R7 load write without force leaves count alone
    wr(3'd2, 32'd40);
    rd(3'd4, v); chk("R7", "no force", v, 32'd94);
    wr(3'd0, K_RUN | K_FORCE | src_bits(1));
    wr(3'd2, 32'd2);
    rd(3'd4, v); chk("R7", "force beats step", v, 32'd2);

    // R5 free-running wrap
    idle(3);
    rd(3'd4, v); chk("R5", "wrap to ones", v, ONES);
    idle(1);
    rd(3'd4, v); chk("R5", "after wrap", v, 32'hFFFF_FFFE);

    // R5 reload mode
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd3);
    wr(3'd0, K_RUN | K_RST | K_RLD | src_bits(1));
    idle(4);
    rd(3'd4, v); chk("R5", "reload at zero", v, 32'd3);
    idle(1);
    rd(3'd4, v); chk("R5", "after reload", v, 32'd2);

    // R6 restart without reload, hold, edge without restart
    wr(3'd0, 32'd0);
    wr(3'd0, K_RUN | K_RST | src_bits(1));
    rd(3'd4, v); chk("R6", "restart ones", v, ONES);
    wr(3'd0, 32'd0);
    idle(5);
    rd(3'd4, v); chk("R6", "hold stopped", v, 32'hFFFF_FFFE);
    wr(3'd0, K_RUN | src_bits(1));
    rd(3'd4, v); chk("R6", "no restart", v, 32'hFFFF_FFFE);

    // R8 R9 compare flag and interrupt gating
    wr(3'd0, 32'd0);
    wr(3'd0, K_FORCE);
    wr(3'd3, 32'd5);
    wr(3'd2, 32'd8);
    wr(3'd0, K_RUN | src_bits(1));
    idle(3);
    rd(3'd4, v); chk("R8", "count at cmp", v, 32'd5);
    rd(3'd1, v); chk("R8", "flag set", v, 32'd1);
    chk("R9", "irq disabled", 32'(irq), 32'd0);
    wr(3'd0, K_RUN | K_IEN | src_bits(1));
    chk("R9", "irq high", 32'(irq), 32'd1);
    wr(3'd1, 32'd0);
    rd(3'd1, v); chk("R8", "write 0 ignored", v, 32'd1);
    wr(3'd0, K_IEN | src_bits(1));
    chk("R9", "irq needs run", 32'(irq), 32'd0);
    wr(3'd1, 32'd1);
    rd(3'd1, v); chk("R8", "clear", v, 32'd0);

    // R8 set and clear on the same edge
    wr(3'd0, K_FORCE);
    wr(3'd2, 32'd8);
    wr(3'd0, K_RUN | src_bits(1));
    idle(2);
    wr(3'd1, 32'd1);
    rd(3'd1, v); chk("R8", "set beats clear", v, 32'd1);

    // R10 soft reset
    set_ticks(0, 0, 0);
    wr(3'd0, 32'd0);
    wr(3'd3, 32'd9);
    wr(3'd2, 32'd20);
    wr(3'd0, 32'h01BC_005F);
    wr(3'd0, 32'h01BC_005F | K_SRST);
    rd(3'd0, v); chk("R10", "srst visible", v, 32'h01BD_005F);
    idle(1);
    rd(3'd0, v); chk("R10", "ctl kept bits", v, 32'h003C_0003);
    rd(3'd1, v); chk("R10", "status", v, 32'd0);
    rd(3'd2, v); chk("R10", "load", v, ONES);
    rd(3'd3, v); chk("R10", "cmp", v, 32'd0);
    rd(3'd4, v); chk("R10", "count", v, ONES);

    // R2 count register write ignored, unmapped reads zero
    wr(3'd4, 32'h1234);
    rd(3'd4, v); chk("R2", "count read-only", v, ONES);
    rd(3'd5, v); chk("R2", "unmapped", v, 32'd0);

    finish_up();
  end
endmodule